// File: doc/BRIEF.md
# Memory-Mapped Console Port (Keyboard In, Display Out)

This peripheral sits on a simple word-addressed read/write bus and gives software two character channels. The input channel takes bytes from a keyboard source and holds the latest one with a flag that says it is waiting to be read. The output channel takes one byte from software and hands it to a display sink. Each channel has a control word and a data word. The control word carries a ready flag and an interrupt-enable bit. The data word carries one ASCII byte in its low eight bits.

Software can work in either of two ways. It can poll the ready flags. It can also set an enable bit and wait for the shared interrupt request. Reading the input data word consumes the byte. Writing the output data word starts a transfer. Both actions clear the matching ready flag. Bus reads are combinational: `bus_ack` and `bus_rdata` are valid in the cycle where `bus_sel` is high, and side effects take hold at the end of that cycle.

Both character paths are valid/ready streams. The input stream never applies back-pressure: `kb_ready` is always 1, and a byte is taken in every cycle where `kb_valid` is high. The output stream follows the usual rule. Once `dsp_valid` rises, it and `dsp_data` hold steady until a cycle where `dsp_ready` is high. The transfer completes in that cycle.

Top module: `mmio_console`

## Requirements
- R1: After reset:
  - The input ready flag, the overrun bit and both enable bits are 0.
  - The output ready flag is 1.
  - `dsp_valid` and `irq` are 0.
  - The output data word reads 0.
- R2: A byte taken on the input stream sets the input ready flag (control bit 0). Reading the input data word (base+0x4) then returns that byte in bits 7:0, with bits 31:8 reading 0.
- R3: A read of the input data word clears the input ready flag from the next cycle, unless a new byte arrives in the same cycle.
- R4: A byte that arrives while the input ready flag is 1 replaces the held byte and sets the overrun bit (control bit 2). A read of the input control word (base+0x0) returns the overrun bit and then clears it.
- R5: When a new byte arrives in the same cycle as a read of the input data word:
  - The read returns the older byte.
  - The ready flag stays 1.
  - No overrun is recorded.
- R6: A write to the output data word (base+0xC) while the output ready flag is 1 has these effects from the next cycle:
  - It presents bits 7:0 on `dsp_data`.
  - It raises `dsp_valid`.
  - It clears the output ready flag (output control word base+0x8, bit 0).
  - A read of the output data word returns the written byte.
- R7: A write to the output data word while the output ready flag is 0 changes nothing.
- R8: `dsp_valid` and `dsp_data` stay steady until `dsp_ready` is high. After that transfer cycle, `dsp_valid` is 0 and the output ready flag is 1.
- R9: In a control word, only bit 1 (interrupt enable) is writable. Write data in bit 0 and in the other bits is ignored.
- R10: `irq` is 1 exactly when at least one channel has its ready flag and its enable bit both set.
- R11: An access to any address other than the four aligned words gets `bus_ack` 0 and reads 0, and changes no state.
- R12: An access to one of the four aligned words gets `bus_ack` 1 in the same cycle, with its read data on `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| bus_ack | output | 1 | Address decoded to a register |
| kb_valid | input | 1 | Input stream byte present |
| kb_data | input | 8 | Input stream byte |
| kb_ready | output | 1 | Input stream acceptance, always 1 |
| dsp_valid | output | 1 | Output stream byte present |
| dsp_data | output | 8 | Output stream byte |
| dsp_ready | input | 1 | Display sink can take the byte |
| irq | output | 1 | Interrupt request |

## Verification
Two input-channel events can fall in the same cycle: a byte arriving from the keyboard source and a software read of the input data word. The bench places the second byte in the very cycle of the data read. The scoreboard then expects three things: the read returns the older byte, a control read afterwards shows ready 1 with no overrun, and a further data read returns the newer byte. A second case is also covered. A write to the output data word while a transfer is still pending is checked on `dsp_data` to have been dropped.

// File: rtl/mmio_console_pkg.sv
package mmio_console_pkg;
  localparam int NUM_REGS    = 4;
  localparam int IDX_LSB     = 2;
  localparam int IDX_W       = $clog2(NUM_REGS);
  localparam int CTL_RDY_BIT = 0;
  localparam int CTL_IE_BIT  = 1;
  localparam int CTL_OVR_BIT = 2;

  typedef enum logic [IDX_W-1:0] {
    REG_KCTL = 2'd0,
    REG_KDAT = 2'd1,
    REG_DCTL = 2'd2,
    REG_DDAT = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/mc_decode.sv
module mc_decode
  import mmio_console_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
  input  logic                bus_sel,
  input  logic [ADDR_W-1:0]   bus_addr,
  output logic [NUM_REGS-1:0] reg_oh,
  output logic                hit
);
  localparam int WIN_LSB = IDX_LSB + IDX_W;

  logic in_win;

  assign in_win = (bus_addr[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB])
               && (bus_addr[IDX_LSB-1:0] == '0);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign reg_oh[g] = bus_sel && in_win
                    && (bus_addr[IDX_LSB +: IDX_W] == IDX_W'(g));
  end

  assign hit = |reg_oh;
endmodule

// File: rtl/mc_kbd_chan.sv
module mc_kbd_chan #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  output logic              in_ready,
  input  logic              ctl_wr,
  input  logic              ctl_rd,
  input  logic              dat_rd,
  input  logic              ie_wdata,
  output logic              rdy,
  output logic              ovr,
  output logic              ie,
  output logic [CHAR_W-1:0] byte_q
);
  // The held byte is always replaceable, so the stream never stalls.
  assign in_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy    <= 1'b0;
      ovr    <= 1'b0;
      ie     <= 1'b0;
      byte_q <= '0;
    end else begin
      if (ctl_wr) ie <= ie_wdata;

      if (in_valid)    rdy <= 1'b1;
      else if (dat_rd) rdy <= 1'b0;

      // A byte lost only if the held one was unread and not consumed now.
      if (in_valid && rdy && !dat_rd) ovr <= 1'b1;
      else if (ctl_rd)                ovr <= 1'b0;

      if (in_valid) byte_q <= in_data;
    end
  end
endmodule

// File: rtl/mc_dsp_chan.sv
module mc_dsp_chan #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dat_wr,
  input  logic [CHAR_W-1:0] wbyte,
  input  logic              ctl_wr,
  input  logic              ie_wdata,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_data,
  input  logic              out_ready,
  output logic              rdy,
  output logic              ie
);
  logic pend_q;
  logic take_wr;

  assign rdy       = !pend_q;
  assign take_wr   = dat_wr && rdy;
  assign out_valid = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      out_data <= '0;
      ie       <= 1'b0;
    end else begin
      if (ctl_wr) ie <= ie_wdata;

      if (take_wr) begin
        pend_q   <= 1'b1;
        out_data <= wbyte;
      end else if (pend_q && out_ready) begin
        pend_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mmio_console.sv
module mmio_console
  import mmio_console_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                DATA_W    = 32,
  parameter int                CHAR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ack,
  input  logic              kb_valid,
  input  logic [CHAR_W-1:0] kb_data,
  output logic              kb_ready,
  output logic              dsp_valid,
  output logic [CHAR_W-1:0] dsp_data,
  input  logic              dsp_ready,
  output logic              irq
);
  logic [NUM_REGS-1:0] reg_oh;
  logic                hit;
  logic                kb_rdy, kb_ovr, kb_ie;
  logic [CHAR_W-1:0]   kb_byte;
  logic                dsp_rdy, dsp_ie;
  logic                rd_en, wr_en;
  logic                unused_wdata;

  assign rd_en        = bus_sel && !bus_we;
  assign wr_en        = bus_sel && bus_we;
  assign unused_wdata = ^bus_wdata[DATA_W-1:CHAR_W];

  mc_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .bus_sel (bus_sel),
    .bus_addr(bus_addr),
    .reg_oh  (reg_oh),
    .hit     (hit)
  );

  mc_kbd_chan #(.CHAR_W(CHAR_W)) u_kbd (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(kb_valid),
    .in_data (kb_data),
    .in_ready(kb_ready),
    .ctl_wr  (wr_en && reg_oh[REG_KCTL]),
    .ctl_rd  (rd_en && reg_oh[REG_KCTL]),
    .dat_rd  (rd_en && reg_oh[REG_KDAT]),
    .ie_wdata(bus_wdata[CTL_IE_BIT]),
    .rdy     (kb_rdy),
    .ovr     (kb_ovr),
    .ie      (kb_ie),
    .byte_q  (kb_byte)
  );

  mc_dsp_chan #(.CHAR_W(CHAR_W)) u_dsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .dat_wr   (wr_en && reg_oh[REG_DDAT]),
    .wbyte    (bus_wdata[CHAR_W-1:0]),
    .ctl_wr   (wr_en && reg_oh[REG_DCTL]),
    .ie_wdata (bus_wdata[CTL_IE_BIT]),
    .out_valid(dsp_valid),
    .out_data (dsp_data),
    .out_ready(dsp_ready),
    .rdy      (dsp_rdy),
    .ie       (dsp_ie)
  );

  always_comb begin
    bus_rdata = '0;
    if (reg_oh[REG_KCTL]) begin
      bus_rdata[CTL_RDY_BIT] = kb_rdy;
      bus_rdata[CTL_IE_BIT]  = kb_ie;
      bus_rdata[CTL_OVR_BIT] = kb_ovr;
    end
    if (reg_oh[REG_KDAT]) bus_rdata[CHAR_W-1:0] = kb_byte;
    if (reg_oh[REG_DCTL]) begin
      bus_rdata[CTL_RDY_BIT] = dsp_rdy;
      bus_rdata[CTL_IE_BIT]  = dsp_ie;
    end
    if (reg_oh[REG_DDAT]) bus_rdata[CHAR_W-1:0] = dsp_data;
  end

  assign bus_ack = hit;
  assign irq     = (kb_rdy && kb_ie) || (dsp_rdy && dsp_ie);
endmodule

// File: rtl/mmio_console_chk.sv
module mmio_console_chk #(
  parameter int                ADDR_W    = 32,
  parameter int                DATA_W    = 32,
  parameter int                CHAR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_ack,
  input logic              kb_valid,
  input logic              dsp_valid,
  input logic [CHAR_W-1:0] dsp_data,
  input logic              dsp_ready,
  input logic              irq,
  input logic              kb_rdy,
  input logic              dsp_rdy
);
  logic a_kdat, a_ddat, a_known;

  assign a_kdat  = bus_addr == BASE_ADDR + ADDR_W'(4);
  assign a_ddat  = bus_addr == BASE_ADDR + ADDR_W'(12);
  assign a_known = (bus_addr == BASE_ADDR) || a_kdat
                || (bus_addr == BASE_ADDR + ADDR_W'(8)) || a_ddat;

  // R2
  kb_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kb_valid |=> kb_rdy);

  // R3
  kb_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && a_kdat && !kb_valid) |=> !kb_rdy);

  // R6
  dsp_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && a_ddat && dsp_rdy)
      |=> (dsp_valid && !dsp_rdy && dsp_data == $past(bus_wdata[CHAR_W-1:0])));

  // R8
  dsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_valid && !dsp_ready) |=> (dsp_valid && $stable(dsp_data)));

  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (kb_rdy || dsp_rdy));

  // R11
  stray_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !a_known) |-> (!bus_ack && bus_rdata == '0));
endmodule

bind mmio_console mmio_console_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_sel  (bus_sel),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .bus_ack  (bus_ack),
  .kb_valid (kb_valid),
  .dsp_valid(dsp_valid),
  .dsp_data (dsp_data),
  .dsp_ready(dsp_ready),
  .irq      (irq),
  .kb_rdy   (kb_rdy),
  .dsp_rdy  (dsp_rdy)
);

// File: tb/mmio_console_bench.sv
module mmio_console_bench;
  localparam logic [31:0] B    = 32'hFFFF_0000;
  localparam logic [31:0] KCTL = B;
  localparam logic [31:0] KDAT = B + 32'h4;
  localparam logic [31:0] DCTL = B + 32'h8;
  localparam logic [31:0] DDAT = B + 32'hC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic        bus_ack;
  logic        kb_valid = 1'b0, kb_ready;
  logic [7:0]  kb_data = '0;
  logic        dsp_valid, dsp_ready = 1'b0, irq;
  logic [7:0]  dsp_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  bit          ack_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  mmio_console u_mmio_console (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .kb_valid(kb_valid), .kb_data(kb_data),
    .kb_ready(kb_ready), .dsp_valid(dsp_valid), .dsp_data(dsp_data),
    .dsp_ready(dsp_ready), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // One bus cycle, driven just after the rising edge.
  task automatic cyc(input logic sel, input logic we, input logic [31:0] a,
                     input logic [31:0] wd, input logic kv, input logic [7:0] kd,
                     input logic sr);
    @(posedge clk);
    #2;
    bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = wd;
    kb_valid = kv; kb_data = kd; dsp_ready = sr;
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, '0, '0, 1'b0, '0, 1'b0);
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    cyc(1'b1, 1'b1, a, d, 1'b0, '0, 1'b0);
  endtask

  task automatic key(input logic [7:0] b);
    cyc(1'b0, 1'b0, '0, '0, 1'b1, b, 1'b0);
  endtask

  // Read with optional coincident keyboard byte; expectation goes to scoreboard.
  task automatic rdk(input logic [31:0] a, input logic [31:0] exp, input bit ack,
                     input logic kv, input logic [7:0] kd, input string tag);
    cyc(1'b1, 1'b0, a, '0, kv, kd, 1'b0);
    exp_q.push_back(exp);
    ack_q.push_back(ack);
    tag_q.push_back(tag);
  endtask

  task automatic rd(input logic [31:0] a, input logic [31:0] exp, input string tag);
    rdk(a, exp, 1'b1, 1'b0, '0, tag);
  endtask

  // Monitor: pops one expectation per read, sampled mid-cycle.
  always @(negedge clk) begin
    if (rst_n && bus_sel && !bus_we) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R12: unexpected read, got %h expected none", bus_rdata);
      end else begin
        chk(tag_q[0], bus_rdata, exp_q[0]);
        chk({"R12 ack ", tag_q[0]}, {31'b0, bus_ack}, {31'b0, ack_q[0]});
        void'(exp_q.pop_front());
        void'(ack_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    idle();
    @(negedge clk);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 dsp_valid", {31'b0, dsp_valid}, 32'h0);
    chk("R1 kb_ready always 1", {31'b0, kb_ready}, 32'h1);
    rd(KCTL, 32'h0, "R1 kbd ctl");
    rd(DCTL, 32'h1, "R1 dsp ctl");
    rd(DDAT, 32'h0, "R1 dsp dat");

    key(8'h41);
    rd(KCTL, 32'h1, "R2 ready set");
    rd(KDAT, 32'h41, "R2 byte");
    rd(KCTL, 32'h0, "R3 cleared by read");

    key(8'h42);
    key(8'h43);
    rd(KCTL, 32'h5, "R4 overrun set");
    rd(KCTL, 32'h1, "R4 overrun cleared");
    rd(KDAT, 32'h43, "R4 byte replaced");

    key(8'h44);
    rdk(KDAT, 32'h44, 1'b1, 1'b1, 8'h45, "R5 old byte");
    rd(KCTL, 32'h1, "R5 ready kept no overrun");
    rd(KDAT, 32'h45, "R5 new byte");

    wr(KCTL, 32'hFFFF_FFFF);
    idle();
    @(negedge clk);
    chk("R10 irq off while empty", {31'b0, irq}, 32'h0);
    rd(KCTL, 32'h2, "R9 only ie written");
    key(8'h46);
    idle();
    @(negedge clk);
    chk("R10 irq kbd", {31'b0, irq}, 32'h1);
    rd(KDAT, 32'h46, "R10 byte");
    idle();
    @(negedge clk);
    chk("R10 irq dropped", {31'b0, irq}, 32'h0);
    wr(KCTL, 32'h0);

    wr(DDAT, 32'h0000_0158);
    idle();
    @(negedge clk);
    chk("R6 dsp_valid", {31'b0, dsp_valid}, 32'h1);
    chk("R6 dsp_data", {24'b0, dsp_data}, 32'h58);
    rd(DCTL, 32'h0, "R6 ready cleared");
    rd(DDAT, 32'h58, "R6 readback");
    wr(DDAT, 32'h59);
    idle();
    @(negedge clk);
    chk("R7 write dropped", {24'b0, dsp_data}, 32'h58);
    chk("R8 still valid", {31'b0, dsp_valid}, 32'h1);
    rd(DDAT, 32'h58, "R7 readback");
    wr(DCTL, 32'h3);
    rd(DCTL, 32'h2, "R9 dsp ready bit ignored");
    idle();
    @(negedge clk);
    chk("R10 irq off while busy", {31'b0, irq}, 32'h0);
    cyc(1'b0, 1'b0, '0, '0, 1'b0, '0, 1'b1);
    idle();
    @(negedge clk);
    chk("R8 valid drops", {31'b0, dsp_valid}, 32'h0);
    chk("R10 irq dsp", {31'b0, irq}, 32'h1);
    rd(DCTL, 32'h3, "R8 ready back");
    wr(DCTL, 32'h0);

    rdk(B + 32'h10, 32'h0, 1'b0, 1'b0, '0, "R11 past window");
    rdk(32'h0000_0004, 32'h0, 1'b0, 1'b0, '0, "R11 low address");
    rdk(B + 32'h2, 32'h0, 1'b0, 1'b0, '0, "R11 misaligned");
    wr(B + 32'h1, 32'h2);
    wr(B + 32'h14, 32'h2);
    rd(KCTL, 32'h0, "R11 no state change");
    idle();
    @(negedge clk);
    chk("R11 irq quiet", {31'b0, irq}, 32'h0);
    chk("R11 scoreboard drained", exp_q.size(), 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule